// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave side of a four-wire style serial control link. It gives an external controller read and write access to a bank of 8-bit configuration registers. Every access opens with one command byte, followed by one to four data bytes, all framed by an active-low select. The register at address 0 holds two mode bits. One picks the bit order on the wire. The other picks whether read data leaves on the shared data pin or on a dedicated output pin.

The link pins are sampled in the system clock domain and are expected to be synchronous to it. A rising edge on the serial clock moves one bit in. Read data for the next bit appears in the system clock cycle after the rising edge that completed the previous bit. For multibyte accesses, the port steps the register address by itself after each data byte. The bit-order mode sets the direction of that step.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset every register reads as 0x00, so the port starts MSB-first in single-pin mode, and both output enables are low.
- R2: The command byte carries the direction in bit 7 (1 = read, 0 = write), a length code in bits 6:5 and the start address in bits 4:0. Bit positions refer to the byte value, independent of the order on the wire.
- R3: Length code 2'b00 transfers one data byte, 2'b10 two, 2'b01 three and 2'b11 four.
- R4: With register 0 bit 6 clear, bits are taken on each rising serial clock edge, bit 7 first. After each data byte the address decrements, wrapping from 0 to the top address.
- R5: With register 0 bit 6 set, bit 0 goes first on the wire. After each data byte the address increments, wrapping from the top address to 0.
- R6: A write updates the addressed register at the end of each complete data byte. Bytes sent after the coded length are ignored until select rises.
- R7: During a read data phase, the output bit equals the addressed register's bit for the next wire position. It is valid from the system clock cycle after the rising edge that completed the previous bit.
- R8: With register 0 bit 7 clear, the shared pin enable is high only during a read data phase while select is low, and the dedicated output enable stays low.
- R9: With register 0 bit 7 set, read data drives the dedicated output under its own enable. The shared pin enable never rises, and the two enables are never high together.
- R10: Raising select at any point returns the port to the command phase. A partially received byte is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock, sampled by clk |
| cs_n | input | 1 | Active-low transaction select |
| sdio_in | input | 1 | Serial data input (shared pin receive side) |
| sdio_out | output | 1 | Read data for the shared pin |
| sdio_oe | output | 1 | Drive enable for the shared pin |
| sdo_out | output | 1 | Read data for the dedicated output pin |
| sdo_oe | output | 1 | Drive enable for the dedicated output pin |

## Verification
A corrupted bit counter or a wrong shift direction appears as a wrong read bit on the very next data position. A wrong address step appears only on the second byte of a multibyte read, which is why reads of two, three and four bytes are used. A stale phase after an aborted access appears either as an output enable rising at the wrong time, caught within one system clock, or as a register value that differs from what was written, seen on the next read-back. The mode bits in register 0 are changed mid-run so that errors in order or pin selection appear within a few bytes.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

   localparam int BYTE_W      = 8;
   localparam int DIR_BIT     = 7;
   localparam int LEN_HI      = 6;
   localparam int LEN_LO      = 5;
   localparam int ADDR_FIELD  = 5;
   localparam int MODE_LSB    = 6;
   localparam int MODE_SPLIT  = 7;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_DATA = 2'd1,
      PH_IDLE = 2'd2
   } phase_t;

   // Non-monotonic length code to byte count
   function automatic logic [2:0] len_decode(input logic [1:0] code);
      case (code)
         2'b00:   len_decode = 3'd1;
         2'b01:   len_decode = 3'd3;
         2'b10:   len_decode = 3'd2;
         default: len_decode = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/cfgsp_shifter.sv
module cfgsp_shifter
   import cfgsp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   input  logic              lsb_first,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_val,
   output logic [2:0]        bit_idx
);

   logic              sclk_q;
   logic              rise;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] shnext;

   always_comb begin
      rise   = sclk & ~sclk_q & ~cs_n;
      shnext = lsb_first ? {sdi, shreg[BYTE_W-1:1]} : {shreg[BYTE_W-2:0], sdi};
      byte_done = rise && (bit_idx == 3'd7);
      byte_val  = shnext;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         shreg   <= '0;
         bit_idx <= '0;
      end else begin
         sclk_q <= sclk;
         if (cs_n) begin
            bit_idx <= '0;
         end else if (rise) begin
            shreg   <= shnext;
            bit_idx <= bit_idx + 3'd1;
         end
      end
   end

   AST_ABORT_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (bit_idx == 3'd0)); // R10

endmodule

// File: rtl/cfgsp_seq.sv
module cfgsp_seq
   import cfgsp_pkg::*;
#(
   parameter int ADDR_W = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              byte_done,
   input  logic [BYTE_W-1:0] byte_val,
   input  logic              lsb_first,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic              rd_phase
);

   phase_t     phase;
   logic       is_read;
   logic [2:0] remain;

   generate
      if (ADDR_W < 1 || ADDR_W > ADDR_FIELD) begin : g_bad_addr
         $error("cfgsp_seq: ADDR_W must be 1..5");
      end
   endgenerate

   always_comb begin
      wr_en    = byte_done && (phase == PH_DATA) && !is_read;
      rd_phase = (phase == PH_DATA) && is_read;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_CMD;
         is_read <= 1'b0;
         remain  <= '0;
         addr    <= '0;
      end else if (cs_n) begin
         phase <= PH_CMD;
      end else if (byte_done) begin
         case (phase)
            PH_CMD: begin
               is_read <= byte_val[DIR_BIT];
               remain  <= len_decode(byte_val[LEN_HI:LEN_LO]);
               addr    <= byte_val[ADDR_W-1:0];
               phase   <= PH_DATA;
            end
            PH_DATA: begin
               addr   <= lsb_first ? addr + 1'b1 : addr - 1'b1;
               remain <= remain - 3'd1;
               if (remain == 3'd1) phase <= PH_IDLE;
            end
            default: ;
         endcase
      end
   end

   AST_CS_RETURNS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (phase == PH_CMD)); // R10
   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA) |-> (remain >= 3'd1 && remain <= 3'd4)); // R3
   AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && byte_done) |=> (addr != $past(addr))); // R4

endmodule

// File: rtl/cfgsp_regs.sv
module cfgsp_regs
   import cfgsp_pkg::*;
#(
   parameter int ADDR_W = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rd_data,
   output logic              cfg_lsb,
   output logic              cfg_split
);

   localparam int NREGS = 1 << ADDR_W;

   logic [BYTE_W-1:0] bank [NREGS];

   generate
      if (ADDR_W < 1 || ADDR_W > ADDR_FIELD) begin : g_bad_addr
         $error("cfgsp_regs: ADDR_W must be 1..5");
      end
      for (genvar g = 0; g < NREGS; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bank[g] <= '0;
            else if (wr_en && (addr == ADDR_W'(g)))
               bank[g] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rd_data   = bank[addr];
      cfg_lsb   = bank[0][MODE_LSB];
      cfg_split = bank[0][MODE_SPLIT];
   end

   AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == '0) |=> $stable({cfg_lsb, cfg_split})); // R6

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
   import cfgsp_pkg::*;
#(
   parameter int ADDR_W = 5
)(
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic sdio_in,
   output logic sdio_out,
   output logic sdio_oe,
   output logic sdo_out,
   output logic sdo_oe
);

   logic              byte_done;
   logic [BYTE_W-1:0] byte_val;
   logic [2:0]        bit_idx;
   logic [ADDR_W-1:0] addr;
   logic              wr_en;
   logic              rd_phase;
   logic [BYTE_W-1:0] rd_data;
   logic              cfg_lsb;
   logic              cfg_split;
   logic              out_bit;
   logic              rd_active;

   generate
      if (ADDR_W < 1 || ADDR_W > ADDR_FIELD) begin : g_bad_addr
         $error("cfg_serial_port: ADDR_W must be 1..5");
      end
   endgenerate

   cfgsp_shifter i_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk      (sclk),
      .cs_n      (cs_n),
      .sdi       (sdio_in),
      .lsb_first (cfg_lsb),
      .byte_done (byte_done),
      .byte_val  (byte_val),
      .bit_idx   (bit_idx)
   );

   cfgsp_seq #(.ADDR_W(ADDR_W)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .byte_done (byte_done),
      .byte_val  (byte_val),
      .lsb_first (cfg_lsb),
      .addr      (addr),
      .wr_en     (wr_en),
      .rd_phase  (rd_phase)
   );

   cfgsp_regs #(.ADDR_W(ADDR_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (byte_val),
      .rd_data   (rd_data),
      .cfg_lsb   (cfg_lsb),
      .cfg_split (cfg_split)
   );

   always_comb begin
      out_bit   = rd_data[cfg_lsb ? bit_idx : 3'd7 - bit_idx];
      rd_active = rd_phase & ~cs_n;
      sdio_oe   = rd_active & ~cfg_split;
      sdo_oe    = rd_active & cfg_split;
      sdio_out  = sdio_oe & out_bit;
      sdo_out   = sdo_oe & out_bit;
   end

   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      !(sdio_oe && sdo_oe)); // R9
   AST_WRITE_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (byte_done && !cs_n)); // R6
   AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> !rd_phase || !sdio_oe); // R8

endmodule

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic sdio_in = 1'b0;
   logic sdio_out, sdio_oe, sdo_out, sdo_oe;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit cmp_en = 1'b0;
   bit tb_lsb = 1'b0;
   bit tb_split = 1'b0;
   logic [7:0] wbuf [4];
   logic [7:0] rbuf [4];

   always #2 clk = ~clk;   // 250 MHz

   cfg_serial_port i_cfg_serial_port (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
      .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
   );

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_regs [32];
   int  m_phase = 0;     // 0 command, 1 data, 2 ignore
   int  m_cnt = 0;
   int  m_left = 0;
   int  m_addr = 0;
   bit  m_read = 0;
   bit  m_sclk_q = 0;
   logic [7:0] m_sh = 0;

   initial for (int i = 0; i < 32; i++) m_regs[i] = 8'h00;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_cnt = 0; m_sclk_q = 0; m_sh = 0; m_addr = 0; m_read = 0; m_left = 0;
         for (int i = 0; i < 32; i++) m_regs[i] = 8'h00;
      end else begin
         if (cs_n) begin
            m_phase = 0; m_cnt = 0;
         end else if (sclk && !m_sclk_q) begin
            bit lsb;
            lsb = m_regs[0][6];
            m_sh = lsb ? {sdio_in, m_sh[7:1]} : {m_sh[6:0], sdio_in};
            if (m_cnt == 7) begin
               m_cnt = 0;
               if (m_phase == 0) begin
                  m_read = m_sh[7];
                  case (m_sh[6:5])
                     2'b00: m_left = 1;
                     2'b10: m_left = 2;
                     2'b01: m_left = 3;
                     default: m_left = 4;
                  endcase
                  m_addr = m_sh[4:0];
                  m_phase = 1;
               end else if (m_phase == 1) begin
                  if (!m_read) m_regs[m_addr] = m_sh;
                  m_addr = lsb ? (m_addr + 1) % 32 : (m_addr + 31) % 32;
                  m_left = m_left - 1;
                  if (m_left == 0) m_phase = 2;
               end
            end else begin
               m_cnt = m_cnt + 1;
            end
         end
         m_sclk_q = sclk;
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (cmp_en) begin
         bit rd, spl, lsb, eb;
         rd  = (m_phase == 1) && m_read && !cs_n;
         spl = m_regs[0][7];
         lsb = m_regs[0][6];
         eb  = m_regs[m_addr][lsb ? m_cnt : 7 - m_cnt];
         checks++;
         if (sdio_oe !== (rd && !spl)) begin
            fails++; $display("FAIL R8 sdio_oe got %0b exp %0b at %0t", sdio_oe, rd && !spl, $time);
         end
         checks++;
         if (sdo_oe !== (rd && spl)) begin
            fails++; $display("FAIL R9 sdo_oe got %0b exp %0b at %0t", sdo_oe, rd && spl, $time);
         end
         if (rd) begin
            checks++;
            if ((spl ? sdo_out : sdio_out) !== eb) begin
               fails++; $display("FAIL R7 data bit got %0b exp %0b at %0t",
                                 spl ? sdo_out : sdio_out, eb, $time);
            end
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++; fails++;
         $display("FAIL watchdog expired got %0d cycles exp fewer", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic one_bit(input logic b, output logic r);
      sdio_in = b; sclk = 1'b0;
      tick(); tick();
      r = tb_split ? sdo_out : sdio_out;
      sclk = 1'b1;
      tick(); tick();
      sclk = 1'b0;
   endtask

   task automatic send_bits(input logic [7:0] b, input int n, output logic [7:0] got);
      got = 8'h00;
      for (int i = 0; i < n; i++) begin
         int idx;
         logic r;
         idx = tb_lsb ? i : 7 - i;
         one_bit(b[idx], r);
         got[idx] = r;
      end
   endtask

   task automatic xfer(input bit rd, input logic [1:0] code, input logic [4:0] a, input int nb);
      logic [7:0] dummy;
      cs_n = 1'b0; tick();
      send_bits({rd, code, a}, 8, dummy);
      for (int k = 0; k < nb; k++) send_bits(rd ? 8'h00 : wbuf[k], 8, rbuf[k]);
      tick(); cs_n = 1'b1; tick(); tick();
   endtask

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++; $display("FAIL %s got %02h exp %02h", tag, got, exp);
      end
   endtask

   task automatic rd1(input string tag, input logic [4:0] a, input logic [7:0] exp);
      xfer(1'b1, 2'b00, a, 1);
      chk(tag, rbuf[0], exp);
   endtask

   // ---------------- scenario ----------------
   initial begin
      logic [7:0] dummy;
      repeat (5) tick();
      rst_n = 1'b1; tick();
      cmp_en = 1'b1;

      // R1: reset state
      chk("R1 enables after reset", {6'd0, sdio_oe, sdo_oe}, 8'h00);
      rd1("R1 reg 0x05 after reset", 5'h05, 8'h00);
      rd1("R1 reg 0x1F after reset", 5'h1F, 8'h00);

      // R4/R2: four-byte MSB-first write, address counts down
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
      xfer(1'b0, 2'b11, 5'h0A, 4);
      rd1("R4 decremented address 0x08", 5'h08, 8'h33);
      rd1("R2 write landed at start 0x0A", 5'h0A, 8'h11);
      // R3: two-byte code 10, three-byte code 01
      xfer(1'b1, 2'b10, 5'h0A, 2);
      chk("R3 two-byte read byte0", rbuf[0], 8'h11);
      chk("R3 two-byte read byte1", rbuf[1], 8'h22);
      xfer(1'b1, 2'b01, 5'h09, 3);
      chk("R3 three-byte read byte0", rbuf[0], 8'h22);
      chk("R3 three-byte read byte1", rbuf[1], 8'h33);
      chk("R4 three-byte read byte2", rbuf[2], 8'h44);
      xfer(1'b1, 2'b11, 5'h0A, 4);
      chk("R3 four-byte read byte3", rbuf[3], 8'h44);

      // R5: switch to LSB-first, address counts up
      wbuf[0] = 8'h40; xfer(1'b0, 2'b00, 5'h00, 1); tb_lsb = 1'b1;
      wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
      xfer(1'b0, 2'b01, 5'h10, 3);
      rd1("R5 incremented address 0x12", 5'h12, 8'hC3);
      xfer(1'b1, 2'b10, 5'h10, 2);
      chk("R5 lsb-first read byte0", rbuf[0], 8'hA1);
      chk("R5 lsb-first read byte1", rbuf[1], 8'hB2);
      // R5: wrap from top address to 0
      wbuf[0] = 8'h5A; wbuf[1] = 8'h40;
      xfer(1'b0, 2'b10, 5'h1F, 2);
      rd1("R5 top address before wrap", 5'h1F, 8'h5A);
      rd1("R5 wrapped write to 0x00", 5'h00, 8'h40);

      // R9: two-pin mode
      wbuf[0] = 8'hC0; xfer(1'b0, 2'b00, 5'h00, 1); tb_split = 1'b1;
      rd1("R9 read on dedicated pin", 5'h10, 8'hA1);
      wbuf[0] = 8'h00; xfer(1'b0, 2'b00, 5'h00, 1);
      tb_split = 1'b0; tb_lsb = 1'b0;
      rd1("R8 back to single pin msb-first", 5'h08, 8'h33);

      // R10: abort inside a data byte
      cs_n = 1'b0; tick();
      send_bits({1'b0, 2'b00, 5'h05}, 8, dummy);
      send_bits(8'hFF, 5, dummy);
      tick(); cs_n = 1'b1; tick(); tick();
      rd1("R10 partial byte not written", 5'h05, 8'h00);
      // R10: abort inside the command byte
      cs_n = 1'b0; tick();
      send_bits(8'hE0, 3, dummy);
      tick(); cs_n = 1'b1; tick(); tick();
      rd1("R10 command phase restarted", 5'h08, 8'h33);

      // R6: bytes beyond the coded length are ignored
      wbuf[0] = 8'h77; wbuf[1] = 8'h88;
      xfer(1'b0, 2'b00, 5'h06, 2);
      rd1("R6 first byte written", 5'h06, 8'h77);
      rd1("R6 extra byte ignored", 5'h05, 8'h00);

      repeat (4) tick();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule